// File: doc/BRIEF.md
# Single-Channel Block Move Engine

This block is one channel of a memory-to-memory move engine. Software programs a source address, a destination address, a unit count and a control halfword through a 16-bit register port. When the channel is armed, it moves units one at a time over a simple request/acknowledge memory master. Each unit is a read from the source followed by a write to the destination. Units are either 16 or 32 bits wide. After each unit, each address steps up, steps down or holds.

The parameter `CH_IDX` (0 to 3) selects the per-channel variant:
- the width of the count field;
- how many upper address bits are kept;
- whether the external-request flag is writable;
- whether the special start source drives an audio-feed mode.

Non-immediate starts come from a one-cycle `trig_i` pulse, which an external timing qualifier produces. A finished block can raise a one-cycle interrupt pulse. It can also stay armed for the next trigger.

Top module: `dmach_engine`

## Requirements
- R1: After reset the channel issues no memory request, `irq_o` is low, and the control halfword reads back as zero.
- R2: Register select codes are 0/1 for the source low/high halfword, 2/3 for the destination low/high halfword, 4 for the count and 5 for control. Only select 5 reads back anything; the other codes return zero. The control halfword returns destination mode in bits 6:5, source mode in bits 8:7, repeat in bit 9, wide units in bit 10, external-request flag in bit 11, start source in bits 13:12, interrupt enable in bit 14 and enable in bit 15. Bits 4:0 read zero, and bit 11 reads zero unless `CH_IDX` is 3.
- R3: When a control write takes enable from 0 to 1, the working source, destination and count are loaded from the registers. If the start source is 0 (immediate), the block begins without a trigger.
- R4: Each unit is a read (`mem_we_o`=0) followed by a write (`mem_we_o`=1). A 16-bit read takes `mem_rdata_i[15:0]` and copies it into both halves of the 32-bit write data.
- R5: Address modes are 0 = step up, 1 = step down and 2 = hold. Destination mode 3 steps up, and source mode 3 holds. The step is 2 bytes for 16-bit units and 4 bytes for 32-bit units.
- R6: Bus addresses have bit 0 cleared for 16-bit units and bits 1:0 cleared for 32-bit units.
- R7: The count is masked to 14 bits (16 bits when `CH_IDX` is 3). A masked value of zero means 0x4000 units (0x10000 when `CH_IDX` is 3).
- R8: The source high halfword keeps address bits up to 26 when `CH_IDX` is 0 and up to 27 otherwise. The destination high halfword keeps bits up to 27 only when `CH_IDX` is 3 and up to 26 otherwise.
- R9: When the last unit of a block is written, enable is cleared unless repeat is set and the start source is not immediate. `irq_o` pulses for exactly one cycle if interrupt enable is set.
- R10: A repeating block waits for `trig_i`, reloads the count on each start and continues the source from where it stopped. With destination mode 3, the destination returns to its register value after each block.
- R11: `trig_i` has no effect while the channel is disabled or the start source is immediate.
- R12: On channels 1 and 2, start source 3 moves exactly four 32-bit units to a held destination, whatever the size, count and destination mode fields say.
- R13: A read that returns with `mem_rvalid_i` low leaves the data buffer unchanged, so the write that follows carries the previous unit's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Halfword select for write and read |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_sel_i` |
| trig_i | input | 1 | One-cycle start pulse from the timing qualifier |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write phase, 0 = read phase |
| mem_size_o | output | 1 | 1 = 32-bit unit, 0 = 16-bit unit |
| mem_addr_o | output | ADDR_W | Aligned bus address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Completes the current phase |
| mem_rdata_i | input | 32 | Read data |
| mem_rvalid_i | input | 1 | Read data present with the acknowledge |
| irq_o | output | 1 | Block-complete interrupt pulse |

## Verification
The hardest situations to reach from the ports are the second pass of a repeating block and a read that returns no data.

For the repeat case, the bench arms a trigger-started block with destination mode 3 and fires the trigger twice. It then checks that the source continues across the two passes while the destination restarts.

For the no-data case, the bus model withholds valid data for one address region. The bench steers a block into that region right after a block that left a known value in the buffer. The bench tracks the buffer value it expects from its own responses, and compares every write against it.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

   typedef enum logic [1:0] {
      ADJ_UP     = 2'd0,
      ADJ_DOWN   = 2'd1,
      ADJ_HOLD   = 2'd2,
      ADJ_UP_RLD = 2'd3
   } adj_e;

   typedef enum logic [1:0] {
      GO_NOW     = 2'd0,
      GO_FRAME   = 2'd1,
      GO_LINE    = 2'd2,
      GO_SPECIAL = 2'd3
   } go_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } phase_e;

   // Control fields packed to match bits 14:5 of the control halfword.
   typedef struct packed {
      logic irq_en;
      go_e  go;
      logic xreq;
      logic wide;
      logic rpt;
      adj_e src_adj;
      adj_e dst_adj;
   } ctl_t;

   localparam logic [2:0] SEL_SRC_LO = 3'd0;
   localparam logic [2:0] SEL_SRC_HI = 3'd1;
   localparam logic [2:0] SEL_DST_LO = 3'd2;
   localparam logic [2:0] SEL_DST_HI = 3'd3;
   localparam logic [2:0] SEL_CNT    = 3'd4;
   localparam logic [2:0] SEL_CTL    = 3'd5;

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
   import dmach_pkg::*;
#(
   parameter int CH_IDX = 0,
   parameter int ADDR_W = 28,
   parameter int CNT_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [2:0]        sel_i,
   input  logic [15:0]       wdata_i,
   output logic [15:0]       rdata_o,
   input  logic              en_clr_i,
   output logic [ADDR_W-1:0] src_q_o,
   output logic [ADDR_W-1:0] dst_q_o,
   output logic [CNT_W:0]    cnt_q_o,
   output ctl_t              ctl_q_o,
   output logic              en_q_o,
   output logic              arm_o
);
   localparam int SRC_TOP = (CH_IDX == 0) ? 26 : 27;
   localparam int DST_TOP = (CH_IDX == 3) ? 27 : 26;
   localparam logic [ADDR_W-1:0] SRC_MASK = ADDR_W'((64'd1 << (SRC_TOP + 1)) - 64'd1);
   localparam logic [ADDR_W-1:0] DST_MASK = ADDR_W'((64'd1 << (DST_TOP + 1)) - 64'd1);
   localparam logic [CNT_W:0]    CNT_MAX  = {1'b1, {CNT_W{1'b0}}};

   logic [CNT_W-1:0] cnt_masked;
   logic             xreq_bit;
   ctl_t             ctl_wr;

   assign cnt_masked = wdata_i[CNT_W-1:0];

   generate
      if (CH_IDX == 3) begin : g_xreq_rw
         assign xreq_bit = wdata_i[11];
      end else begin : g_xreq_ro
         assign xreq_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      ctl_wr      = ctl_t'(wdata_i[14:5]);
      ctl_wr.xreq = xreq_bit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q_o <= '0;
         dst_q_o <= '0;
         cnt_q_o <= CNT_MAX;
         ctl_q_o <= '0;
         en_q_o  <= 1'b0;
         arm_o   <= 1'b0;
      end else begin
         arm_o <= 1'b0;
         if (en_clr_i) en_q_o <= 1'b0;
         if (we_i) begin
            case (sel_i)
               SEL_SRC_LO: src_q_o[15:0] <= wdata_i;
               SEL_SRC_HI: src_q_o <= ADDR_W'({wdata_i, src_q_o[15:0]}) & SRC_MASK;
               SEL_DST_LO: dst_q_o[15:0] <= wdata_i;
               SEL_DST_HI: dst_q_o <= ADDR_W'({wdata_i, dst_q_o[15:0]}) & DST_MASK;
               SEL_CNT:    cnt_q_o <= (cnt_masked == '0) ? CNT_MAX : {1'b0, cnt_masked};
               SEL_CTL: begin
                  ctl_q_o <= ctl_wr;
                  en_q_o  <= wdata_i[15];
                  arm_o   <= wdata_i[15] & ~en_q_o;
               end
               default: ;
            endcase
         end
      end
   end

   assign rdata_o = (sel_i == SEL_CTL) ? {en_q_o, ctl_q_o, 5'b0} : 16'h0000;

   AST_XREQ_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (CH_IDX != 3) |-> !ctl_q_o.xreq); // R2
   AST_ARM_ONLY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      arm_o |-> $past(we_i && sel_i == SEL_CTL)); // R3
   AST_CNT_NONZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q_o != '0); // R7
endmodule

// File: rtl/dmach_step.sv
module dmach_step
   import dmach_pkg::*;
#(
   parameter int ADDR_W = 28
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  adj_e              adj_i,
   input  logic              wide_i,
   output logic [ADDR_W-1:0] next_o,
   output logic [ADDR_W-1:0] bus_o
);
   logic [ADDR_W-1:0] delta;

   assign delta = wide_i ? ADDR_W'(4) : ADDR_W'(2);

   always_comb begin
      case (adj_i)
         ADJ_DOWN: next_o = addr_i - delta;
         ADJ_HOLD: next_o = addr_i;
         default:  next_o = addr_i + delta;
      endcase
   end

   assign bus_o = wide_i ? {addr_i[ADDR_W-1:2], 2'b00} : {addr_i[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
   import dmach_pkg::*;
#(
   parameter int CH_IDX = 0,
   parameter int ADDR_W = 28,
   parameter int CNT_W  = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              trig_i,
   input  logic              en_q_i,
   input  logic [ADDR_W-1:0] src_q_i,
   input  logic [ADDR_W-1:0] dst_q_i,
   input  logic [CNT_W:0]    cnt_q_i,
   input  adj_e              dst_adj_i,
   input  adj_e              src_adj_i,
   input  logic              rpt_i,
   input  logic              wide_i,
   input  go_e               go_i,
   input  logic              irq_en_i,
   output logic              en_clr_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic              mem_size_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   input  logic              mem_rvalid_i,
   output logic              irq_o
);
   localparam logic [CNT_W:0] CNT_ONE   = (CNT_W + 1)'(1);
   localparam logic [CNT_W:0] CNT_SOUND = (CNT_W + 1)'(4);

   phase_e            phase_q;
   logic [ADDR_W-1:0] src_w, dst_w;
   logic [CNT_W:0]    cnt_w;
   logic              run_wide;
   adj_e              run_src, run_dst;
   logic [31:0]       buf_q;

   logic              sound_mode;
   logic              trig_ok;
   logic              start;
   logic              unit_done;
   logic              last_unit;
   logic              keep_en;
   logic [ADDR_W-1:0] src_next, dst_next, src_bus, dst_bus;

   generate
      if (CH_IDX == 1 || CH_IDX == 2) begin : g_sound
         assign sound_mode = (go_i == GO_SPECIAL);
      end else begin : g_plain
         assign sound_mode = 1'b0;
      end
   endgenerate

   assign trig_ok   = (go_i == GO_FRAME) || (go_i == GO_LINE) || sound_mode;
   assign start     = (phase_q == ST_IDLE) && en_q_i &&
                      ((arm_i && go_i == GO_NOW) || (!arm_i && trig_i && trig_ok));
   assign unit_done = (phase_q == ST_WR) && mem_ack_i && en_q_i;
   assign last_unit = (cnt_w == CNT_ONE);
   assign keep_en   = rpt_i && (go_i != GO_NOW);
   assign en_clr_o  = unit_done && last_unit && !keep_en;

   dmach_step #(.ADDR_W(ADDR_W)) u_src_step (
      .addr_i (src_w),
      .adj_i  (run_src),
      .wide_i (run_wide),
      .next_o (src_next),
      .bus_o  (src_bus)
   );

   dmach_step #(.ADDR_W(ADDR_W)) u_dst_step (
      .addr_i (dst_w),
      .adj_i  (run_dst),
      .wide_i (run_wide),
      .next_o (dst_next),
      .bus_o  (dst_bus)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= ST_IDLE;
         src_w    <= '0;
         dst_w    <= '0;
         cnt_w    <= CNT_ONE;
         run_wide <= 1'b0;
         run_src  <= ADJ_UP;
         run_dst  <= ADJ_UP;
         buf_q    <= '0;
         irq_o    <= 1'b0;
      end else begin
         irq_o <= 1'b0;
         if (arm_i) begin
            src_w <= src_q_i;
            dst_w <= dst_q_i;
            cnt_w <= cnt_q_i;
         end
         if (start) begin
            phase_q  <= ST_RD;
            cnt_w    <= sound_mode ? CNT_SOUND : cnt_q_i;
            run_wide <= sound_mode ? 1'b1 : wide_i;
            run_dst  <= sound_mode ? ADJ_HOLD : dst_adj_i;
            run_src  <= (src_adj_i == ADJ_UP_RLD) ? ADJ_HOLD : src_adj_i;
         end else if (phase_q != ST_IDLE && !en_q_i) begin
            phase_q <= ST_IDLE;
         end else if (phase_q == ST_RD && mem_ack_i) begin
            phase_q <= ST_WR;
            if (mem_rvalid_i)
               buf_q <= run_wide ? mem_rdata_i : {mem_rdata_i[15:0], mem_rdata_i[15:0]};
         end else if (unit_done) begin
            src_w <= src_next;
            dst_w <= dst_next;
            cnt_w <= cnt_w - CNT_ONE;
            if (last_unit) begin
               phase_q <= ST_IDLE;
               irq_o   <= irq_en_i;
               if (keep_en && dst_adj_i == ADJ_UP_RLD) dst_w <= dst_q_i;
            end else begin
               phase_q <= ST_RD;
            end
         end
      end
   end

   assign mem_req_o   = (phase_q != ST_IDLE);
   assign mem_we_o    = (phase_q == ST_WR);
   assign mem_size_o  = run_wide;
   assign mem_addr_o  = (phase_q == ST_WR) ? dst_bus : src_bus;
   assign mem_wdata_o = buf_q;

   AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_we_o && mem_ack_i && en_q_i) |=> (mem_req_o && mem_we_o)); // R4
   AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o && !mem_ack_i) |=> $stable(mem_wdata_o)); // R4
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o); // R9
   AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(mem_req_o && mem_we_o && mem_ack_i)); // R9
   AST_SIZE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && $past(mem_req_o)) |-> $stable(mem_size_o)); // R12
   AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (cnt_w != '0)); // R7
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
   import dmach_pkg::*;
#(
   parameter int CH_IDX = 1,
   parameter int ADDR_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we_i,
   input  logic [2:0]        reg_sel_i,
   input  logic [15:0]       reg_wdata_i,
   output logic [15:0]       reg_rdata_o,
   input  logic              trig_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic              mem_size_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   input  logic              mem_rvalid_i,
   output logic              irq_o
);
   localparam int CNT_W = (CH_IDX == 3) ? 16 : 14;

   generate
      if (CH_IDX < 0 || CH_IDX > 3) begin : g_bad_ch
         $error("dmach_engine: CH_IDX must be 0..3");
      end
      if (ADDR_W < 28 || ADDR_W > 32) begin : g_bad_aw
         $error("dmach_engine: ADDR_W must be 28..32");
      end
   endgenerate

   logic [ADDR_W-1:0] src_q, dst_q;
   logic [CNT_W:0]    cnt_q;
   ctl_t              ctl_q;
   logic              en_q, arm, en_clr;

   dmach_regs #(.CH_IDX(CH_IDX), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (reg_we_i),
      .sel_i    (reg_sel_i),
      .wdata_i  (reg_wdata_i),
      .rdata_o  (reg_rdata_o),
      .en_clr_i (en_clr),
      .src_q_o  (src_q),
      .dst_q_o  (dst_q),
      .cnt_q_o  (cnt_q),
      .ctl_q_o  (ctl_q),
      .en_q_o   (en_q),
      .arm_o    (arm)
   );

   dmach_seq #(.CH_IDX(CH_IDX), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .arm_i        (arm),
      .trig_i       (trig_i),
      .en_q_i       (en_q),
      .src_q_i      (src_q),
      .dst_q_i      (dst_q),
      .cnt_q_i      (cnt_q),
      .dst_adj_i    (ctl_q.dst_adj),
      .src_adj_i    (ctl_q.src_adj),
      .rpt_i        (ctl_q.rpt),
      .wide_i       (ctl_q.wide),
      .go_i         (ctl_q.go),
      .irq_en_i     (ctl_q.irq_en),
      .en_clr_o     (en_clr),
      .mem_req_o    (mem_req_o),
      .mem_we_o     (mem_we_o),
      .mem_size_o   (mem_size_o),
      .mem_addr_o   (mem_addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .mem_ack_i    (mem_ack_i),
      .mem_rdata_i  (mem_rdata_i),
      .mem_rvalid_i (mem_rvalid_i),
      .irq_o        (irq_o)
   );

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !$past(en_q)) |-> !mem_req_o); // R11
   AST_NO_REQ_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> !mem_req_o); // R3
endmodule

// File: tb/dmach_engine_test.sv
module dmach_engine_test;
   localparam int AW = 28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_sel = 3'd0;
   logic [15:0]   reg_wdata = 16'h0;
   logic [15:0]   reg_rdata;
   logic          trig = 1'b0;
   logic          mem_req, mem_we, mem_size;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata;
   logic          mem_ack = 1'b0;
   logic [31:0]   mem_rdata = 32'h0;
   logic          mem_rvalid = 1'b0;
   logic          irq;

   always #2.5 clk = ~clk;

   dmach_engine #(.CH_IDX(1), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .trig_i(trig),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
      .mem_rdata_i(mem_rdata), .mem_rvalid_i(mem_rvalid), .irq_o(irq)
   );

   int n_chk = 0, n_bad = 0;
   bit done_flag = 0;

   // bus model log
   int          wr_n, rd_n, wr_bad, irq_n, irq_dbl;
   logic [31:0] first_w, last_w, last_r, exp_buf;
   bit          saw16, irq_prev;

   function automatic logic [31:0] pat(logic [31:0] a, logic wide);
      if (wide) return {a[15:0] ^ 16'h5A5A, a[15:0] ^ 16'h0F0F};
      return {16'hDEAD, a[15:0] ^ 16'h3C3C};
   endfunction

   initial exp_buf = 32'h0;

   always @(negedge clk) begin
      if (irq) begin
         irq_n++;
         if (irq_prev) irq_dbl++;
      end
      irq_prev = irq;
      if (mem_req) begin
         mem_ack = 1'b1;
         if (!mem_we) begin
            rd_n++;
            last_r = 32'(mem_addr);
            mem_rvalid = (mem_addr[27:24] != 4'hE);
            mem_rdata  = pat(32'(mem_addr), mem_size);
            if (mem_rvalid)
               exp_buf = mem_size ? mem_rdata : {mem_rdata[15:0], mem_rdata[15:0]};
         end else begin
            wr_n++;
            if (wr_n == 1) first_w = 32'(mem_addr);
            last_w = 32'(mem_addr);
            if (!mem_size) saw16 = 1;
            if (mem_wdata !== exp_buf) wr_bad++;
            mem_rvalid = 1'b0;
         end
      end else begin
         mem_ack = 1'b0;
         mem_rvalid = 1'b0;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clr_log();
      @(negedge clk); #1;
      wr_n = 0; rd_n = 0; wr_bad = 0; irq_n = 0; irq_dbl = 0; saw16 = 0;
      first_w = '0; last_w = '0; last_r = '0;
   endtask

   task automatic wreg(logic [2:0] s, logic [15:0] d);
      @(negedge clk); #1;
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rreg(logic [2:0] s, output logic [15:0] d);
      @(negedge clk); #1;
      reg_sel = s;
      #1 d = reg_rdata;
   endtask

   task automatic pulse_trig();
      @(negedge clk); #1;
      trig = 1'b1;
      @(negedge clk); #1;
      trig = 1'b0;
   endtask

   task automatic wait_units(int n);
      for (int k = 0; k < n * 3 + 40 && wr_n < n; k++) @(negedge clk);
      repeat (8) @(negedge clk);
   endtask

   task automatic load_addr(logic [31:0] s, logic [31:0] d, logic [15:0] c);
      wreg(3'd0, s[15:0]); wreg(3'd1, s[31:16]);
      wreg(3'd2, d[15:0]); wreg(3'd3, d[31:16]);
      wreg(3'd4, c);
   endtask

   typedef struct packed {
      logic [15:0] ctl;
      logic [31:0] src;
      logic [31:0] dst;
      logic [15:0] cnt;
      logic [31:0] n;
      logic [31:0] lr;
      logic [31:0] fw;
      logic [31:0] lw;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{16'hC000, 32'h02001000, 32'h03000000, 16'd4,     32'd4,     32'h02001006, 32'h03000000, 32'h03000006},
      '{16'hC4A0, 32'h02002010, 32'h03000100, 16'd3,     32'd3,     32'h02002008, 32'h03000100, 32'h030000F8},
      '{16'h8100, 32'h02000003, 32'h03000005, 16'd3,     32'd3,     32'h02000002, 32'h03000004, 32'h03000008},
      '{16'h85C0, 32'h02000007, 32'h0300000E, 16'd2,     32'd2,     32'h02000004, 32'h0300000C, 32'h0300000C},
      '{16'h8000, 32'h02000000, 32'h03000000, 16'h4002,  32'd2,     32'h02000002, 32'h03000000, 32'h03000002},
      '{16'hC400, 32'hFFFF0000, 32'hFFFF0010, 16'd1,     32'd1,     32'h0FFF0000, 32'h07FF0010, 32'h07FF0010},
      '{16'h8100, 32'h0E000000, 32'h03000040, 16'd2,     32'd2,     32'h0E000000, 32'h03000040, 32'h03000042},
      '{16'h8540, 32'h02000000, 32'h03000000, 16'h0000,  32'd16384, 32'h02000000, 32'h03000000, 32'h03000000},
      '{16'h8200, 32'h02000010, 32'h03000010, 16'd1,     32'd1,     32'h02000010, 32'h03000010, 32'h03000010}
   };

   function automatic string vreq(int i);
      case (i)
         0: return "R3 R5 up/up 16b";
         1: return "R5 down/down 32b";
         2: return "R6 hold src misaligned 16b";
         3: return "R5 R6 src mode 3 holds 32b";
         4: return "R7 count mask";
         5: return "R8 high address bits";
         6: return "R13 no-data read";
         7: return "R7 zero count maximum";
         default: return "R9 repeat with immediate start";
      endcase
   endfunction

   logic [15:0] rd;

   initial begin
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
      chk("R1 irq after reset", 32'(irq), 32'd0);
      rreg(3'd5, rd);
      chk("R1 control readback after reset", 32'(rd), 32'h0);

      // R2 readback: all fields set, enable clear
      wreg(3'd5, 16'h7FFF);
      rreg(3'd5, rd);
      chk("R2 control fields, bit 11 hidden", 32'(rd), 32'h77E0);
      wreg(3'd0, 16'h1234); wreg(3'd4, 16'h0055);
      for (int s = 0; s < 5; s++) begin
         rreg(3'(s), rd);
         chk("R2 non-control halfword reads zero", 32'(rd), 32'h0);
      end
      wreg(3'd5, 16'h0000);

      // Vector table: immediate-start blocks
      for (int i = 0; i < 9; i++) begin
         load_addr(VECS[i].src, VECS[i].dst, VECS[i].cnt);
         clr_log();
         wreg(3'd5, VECS[i].ctl);
         wait_units(int'(VECS[i].n));
         chk({vreq(i), " unit count"}, 32'(wr_n), VECS[i].n);
         chk({vreq(i), " last read addr"}, last_r, VECS[i].lr);
         chk({vreq(i), " first write addr"}, first_w, VECS[i].fw);
         chk({vreq(i), " last write addr"}, last_w, VECS[i].lw);
         chk({vreq(i), " R4 write data"}, 32'(wr_bad), 32'd0);
         chk({vreq(i), " R9 irq pulses"}, 32'(irq_n), 32'(VECS[i].ctl[14]));
         chk({vreq(i), " R9 irq width"}, 32'(irq_dbl), 32'd0);
         rreg(3'd5, rd);
         chk({vreq(i), " R9 enable cleared"}, 32'(rd[15]), 32'd0);
      end

      // R11 trigger while disabled does nothing
      clr_log();
      pulse_trig();
      repeat (10) @(negedge clk);
      chk("R11 trigger while disabled", 32'(wr_n + rd_n), 32'd0);

      // R10 repeat on trigger, dest mode 3 reload, source continues
      load_addr(32'h02000100, 32'h03000200, 16'd2);
      clr_log();
      wreg(3'd5, 16'hD260);
      repeat (10) @(negedge clk);
      chk("R10 no start before trigger", 32'(rd_n), 32'd0);
      pulse_trig();
      wait_units(2);
      chk("R10 first pass units", 32'(wr_n), 32'd2);
      chk("R10 first pass last read", last_r, 32'h02000102);
      chk("R10 first pass last write", last_w, 32'h03000202);
      chk("R10 irq on pass", 32'(irq_n), 32'd1);
      rreg(3'd5, rd);
      chk("R10 enable kept", 32'(rd), 32'hD260);
      clr_log();
      pulse_trig();
      wait_units(2);
      chk("R10 second pass units", 32'(wr_n), 32'd2);
      chk("R10 source continues", last_r, 32'h02000106);
      chk("R10 dest reloaded", first_w, 32'h03000200);
      chk("R10 R4 data", 32'(wr_bad), 32'd0);
      wreg(3'd5, 16'h0000);
      clr_log();
      pulse_trig();
      repeat (10) @(negedge clk);
      chk("R11 trigger after disable", 32'(rd_n), 32'd0);

      // R11 trigger with immediate start source after arming is ignored
      load_addr(32'h02000000, 32'h03000000, 16'd1);
      clr_log();
      wreg(3'd5, 16'h8200);
      wait_units(1);
      clr_log();
      pulse_trig();
      repeat (10) @(negedge clk);
      chk("R11 trigger with immediate source", 32'(rd_n), 32'd0);

      // R12 audio-feed mode: forced four 32-bit units to held destination
      load_addr(32'h02000400, 32'h040000A0, 16'd9);
      clr_log();
      wreg(3'd5, 16'hB200);
      repeat (6) @(negedge clk);
      pulse_trig();
      wait_units(4);
      chk("R12 forced unit count", 32'(wr_n), 32'd4);
      chk("R12 all units 32-bit", 32'(saw16), 32'd0);
      chk("R12 dest held first", first_w, 32'h040000A0);
      chk("R12 dest held last", last_w, 32'h040000A0);
      chk("R12 source stepped", last_r, 32'h0200040C);
      chk("R12 R4 data", 32'(wr_bad), 32'd0);
      rreg(3'd5, rd);
      chk("R12 R9 enable kept", 32'(rd[15]), 32'd1);
      wreg(3'd5, 16'h0000);

      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 190000; c++) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule